// File: doc/BRIEF.md
# SMBus Master Error Status Tracker

This block sits beside an SMBus master engine and a serial EEPROM loader. It turns their single-cycle event pulses into one 32-bit status word that software can read. When the master loses arbitration, the block asks the engine to try again. It keeps a count of losses in a row. Once a fixed number of consecutive losses is reached, it tells the engine to abandon the transaction and records a sticky error instead of asking for another retry.

The other error events latch sticky flags that software clears by writing ones: an unexpected NACK, a START or STOP at an illegal point, a bad loader checksum or missing end-of-configuration command, and a loader write to an undefined register. A read-only done bit records that the loader has stopped, either because it finished or because it hit one of its errors. The status word also carries the slave and master bus addresses. Both are captured from static strap pins while reset is asserted.

The register port is a single word with one write strobe and a read bus that is always valid. All state uses a synchronous active-low reset. Every set event becomes visible on the read bus one clock after its pulse.

Top module: `smb_err_status`

## Requirements
- R1: While reset is held and on the first read after it, the status word has zeros everywhere except bits 7:1 and 15:9, and `retryReq` and `abortReq` are low.
- R2: Bits 7:1 show `strapSlvAddr` and bits 15:9 show `strapMstAddr`, both sampled during reset. A register write never changes them.
- R3: An `evArbLost` pulse that does not bring the consecutive-loss count to 16 produces a one-cycle `retryReq` in the next cycle. It sets no status flag.
- R4: The 16th consecutive `evArbLost` produces a one-cycle `abortReq` in the next cycle and no `retryReq`. It sets bit 26 in that same cycle and restarts the loss count from zero.
- R5: `evArbWon` or `evTxnStart` resets the loss count to zero. If either one arrives in the same cycle as `evArbLost`, the loss is discarded and no retry or abort follows.
- R6: `evNack` sets bit 25 on the next cycle.
- R7: `evBadCond` (a misplaced START or STOP) sets bit 27 on the next cycle.
- R8: `evCsumFail` sets bit 28 and `evUnmapped` sets bit 29. Each of them also sets bit 24.
- R9: `evLoadEnd` sets bit 24. Bit 24 ignores register writes and clears only on reset.
- R10: A write with a 1 in any of bits 25 to 29 clears that flag. Writing a 0 leaves the flag unchanged.
- R11: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R12: Bits 0, 8, 23:16 and 31:30 always read zero, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strapSlvAddr | input | 7 | Slave bus address strap |
| strapMstAddr | input | 7 | Master bus address strap |
| evNack | input | 1 | Unexpected NACK during a master transfer |
| evArbLost | input | 1 | Arbitration attempt lost |
| evArbWon | input | 1 | Arbitration attempt won |
| evTxnStart | input | 1 | New master transaction begins |
| evBadCond | input | 1 | START or STOP seen at an illegal point |
| evCsumFail | input | 1 | Loader checksum bad or end command missing |
| evUnmapped | input | 1 | Loader targeted an undefined register |
| evLoadEnd | input | 1 | Loader completed |
| regWrEn | input | 1 | Status write strobe |
| regWrData | input | 32 | Status write data (ones clear flags) |
| regRdData | output | 32 | Status word |
| retryReq | output | 1 | Pulse asking the engine to arbitrate again |
| abortReq | output | 1 | Pulse telling the engine to abandon the transaction |

## Verification
A vector table drives the error events one at a time and combined with writes, including writes of all ones, of zero and of single bits. This separates set, clear, set-beats-clear and read-only behaviour bit by bit. Runs of exactly 15 losses followed by a 16th test the limit exactly. A run that a win interrupts, and a loss in the same cycle as a win, show that the count really restarts and that a discarded loss produces no retry. Two resets with different strap values show that the address fields follow the straps and are not fixed constants.

// File: rtl/smb_err_status_pkg.sv
package smb_err_status_pkg;
  localparam int STATUS_W = 32;
  localparam int ADDR_W   = 7;
  localparam int SLV_LSB  = 1;
  localparam int MST_LSB  = 9;
  localparam int DONE_BIT = 24;
  localparam int ERR_LSB  = 25;
  localparam int NUM_ERR  = 5;

  // flag index within the sticky error group, offset from ERR_LSB
  localparam int E_NACK  = 0;
  localparam int E_LOST  = 1;
  localparam int E_OTHER = 2;
  localparam int E_CSUM  = 3;
  localparam int E_UNMAP = 4;

  typedef struct packed {
    logic               doneSet;
    logic [NUM_ERR-1:0] errSet;
  } statStrobe_t;
endpackage

// File: rtl/smb_err_status_ctrl.sv
module smb_err_status_ctrl
  import smb_err_status_pkg::*;
#(
  parameter int LOSS_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evNack,
  input  logic        evArbLost,
  input  logic        evArbWon,
  input  logic        evTxnStart,
  input  logic        evBadCond,
  input  logic        evCsumFail,
  input  logic        evUnmapped,
  input  logic        evLoadEnd,
  output statStrobe_t strobe,
  output logic        retryReq,
  output logic        abortReq
);
  localparam int CNT_W = (LOSS_LIMIT > 1) ? $clog2(LOSS_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOSS_LIMIT - 1);

  logic [CNT_W-1:0] lossCnt;
  logic             lossCounted;
  logic             lossAtLimit;
  logic             cntClear;

  // a win or a fresh transaction discards any loss seen in the same cycle
  assign cntClear    = evArbWon | evTxnStart;
  assign lossCounted = evArbLost & ~cntClear;
  assign lossAtLimit = lossCounted & (lossCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lossCnt  <= '0;
      retryReq <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      retryReq <= lossCounted & ~lossAtLimit;
      abortReq <= lossAtLimit;
      if (cntClear || lossAtLimit) begin
        lossCnt <= '0;
      end else if (lossCounted) begin
        lossCnt <= lossCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe                = '0;
    strobe.errSet[E_NACK]  = evNack;
    strobe.errSet[E_LOST]  = lossAtLimit;
    strobe.errSet[E_OTHER] = evBadCond;
    strobe.errSet[E_CSUM]  = evCsumFail;
    strobe.errSet[E_UNMAP] = evUnmapped;
    strobe.doneSet         = evLoadEnd | evCsumFail | evUnmapped;
  end
endmodule

// File: rtl/smb_err_status_data.sv
module smb_err_status_data
  import smb_err_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   strapSlvAddr,
  input  logic [ADDR_W-1:0]   strapMstAddr,
  input  statStrobe_t         strobe,
  input  logic                regWrEn,
  input  logic [STATUS_W-1:0] regWrData,
  output logic [STATUS_W-1:0] regRdData
);
  logic [ADDR_W-1:0]  slvAddr;
  logic [ADDR_W-1:0]  mstAddr;
  logic               doneQ;
  logic [NUM_ERR-1:0] errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slvAddr <= strapSlvAddr;
      mstAddr <= strapMstAddr;
      doneQ   <= 1'b0;
    end else if (strobe.doneSet) begin
      doneQ <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        errQ[i] <= 1'b0;
      end else if (strobe.errSet[i]) begin
        errQ[i] <= 1'b1;
      end else if (regWrEn && regWrData[ERR_LSB+i]) begin
        errQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData                            = '0;
    regRdData[SLV_LSB +: ADDR_W]         = slvAddr;
    regRdData[MST_LSB +: ADDR_W]         = mstAddr;
    regRdData[DONE_BIT]                  = doneQ;
    regRdData[ERR_LSB +: NUM_ERR]        = errQ;
  end
endmodule

// File: rtl/smb_err_status.sv
module smb_err_status
  import smb_err_status_pkg::*;
#(
  parameter int LOSS_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [6:0]  strapSlvAddr,
  input  logic [6:0]  strapMstAddr,
  input  logic        evNack,
  input  logic        evArbLost,
  input  logic        evArbWon,
  input  logic        evTxnStart,
  input  logic        evBadCond,
  input  logic        evCsumFail,
  input  logic        evUnmapped,
  input  logic        evLoadEnd,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        retryReq,
  output logic        abortReq
);
  statStrobe_t strobe;

  smb_err_status_ctrl #(.LOSS_LIMIT(LOSS_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .evNack(evNack), .evArbLost(evArbLost), .evArbWon(evArbWon),
    .evTxnStart(evTxnStart), .evBadCond(evBadCond), .evCsumFail(evCsumFail),
    .evUnmapped(evUnmapped), .evLoadEnd(evLoadEnd),
    .strobe(strobe), .retryReq(retryReq), .abortReq(abortReq)
  );

  smb_err_status_data u_data (
    .clk(clk), .rstN(rstN),
    .strapSlvAddr(strapSlvAddr), .strapMstAddr(strapMstAddr),
    .strobe(strobe), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/smb_err_status_chk.sv
module smb_err_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        evNack,
  input logic        evArbLost,
  input logic        evArbWon,
  input logic        evTxnStart,
  input logic        evBadCond,
  input logic        evCsumFail,
  input logic        evUnmapped,
  input logic        evLoadEnd,
  input logic        regWrEn,
  input logic [31:0] regRdData,
  input logic        retryReq,
  input logic        abortReq
);
  // R3 / R4: a retry never coincides with an abort
  a_r4_no_retry_on_abort: assert property (@(posedge clk) disable iff (!rstN)
    !(retryReq && abortReq));
  // R4: abort is a single-cycle pulse and raises the lost-arbitration flag
  a_r4_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq);
  a_r4_abort_flag: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> regRdData[26]);
  // R3 / R5: a retry only follows a counted loss
  a_r3_retry_cause: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |-> $past(evArbLost && !evArbWon && !evTxnStart));
  // R6 and R11: nack flag is set next cycle even under a clearing write
  a_r6_nack_sets: assert property (@(posedge clk) disable iff (!rstN)
    evNack |=> regRdData[25]);
  // R7
  a_r7_other_sets: assert property (@(posedge clk) disable iff (!rstN)
    evBadCond |=> regRdData[27]);
  // R8 / R9: loader outcomes raise done, which never drops
  a_r8_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evCsumFail || evUnmapped || evLoadEnd) |=> regRdData[24]);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[24] |=> regRdData[24]);
  // R2: address fields hold after reset
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(regRdData[15:0]));
  // R12: reserved bits read zero
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[0] == 1'b0) && (regRdData[8] == 1'b0) &&
    (regRdData[23:16] == 8'h00) && (regRdData[31:30] == 2'b00));
  // R10: a flag only rises through an event or abort
  a_r10_flags_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[29]) |-> $past(evUnmapped));
endmodule

bind smb_err_status smb_err_status_chk u_chk (
  .clk(clk), .rstN(rstN), .evNack(evNack), .evArbLost(evArbLost),
  .evArbWon(evArbWon), .evTxnStart(evTxnStart), .evBadCond(evBadCond),
  .evCsumFail(evCsumFail), .evUnmapped(evUnmapped), .evLoadEnd(evLoadEnd),
  .regWrEn(regWrEn), .regRdData(regRdData), .retryReq(retryReq),
  .abortReq(abortReq)
);

// File: tb/sim_smb_err_status.sv
`timescale 1ns/1ps
module sim_smb_err_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  strapSlvAddr = 7'h2A;
  logic [6:0]  strapMstAddr = 7'h55;
  logic [7:0]  ev = '0; // 0 nack,1 lost,2 won,3 start,4 badcond,5 csum,6 unmapped,7 loadend
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        retryReq, abortReq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smb_err_status u0 (
    .clk(clk), .rstN(rstN), .strapSlvAddr(strapSlvAddr), .strapMstAddr(strapMstAddr),
    .evNack(ev[0]), .evArbLost(ev[1]), .evArbWon(ev[2]), .evTxnStart(ev[3]),
    .evBadCond(ev[4]), .evCsumFail(ev[5]), .evUnmapped(ev[6]), .evLoadEnd(ev[7]),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .retryReq(retryReq), .abortReq(abortReq)
  );

  localparam int NV = 10;
  localparam logic [7:0]  V_EV [NV] = '{8'h01, 8'h10, 8'h00, 8'h02, 8'h20,
                                        8'h00, 8'h40, 8'h00, 8'h01, 8'h00};
  localparam logic        V_WE [NV] = '{0, 0, 1, 0, 0, 1, 1, 1, 1, 1};
  localparam logic [31:0] V_WD [NV] = '{32'h0, 32'h0, 32'h0200FFFF, 32'h0, 32'h0,
                                        32'hFFFFFFFF, 32'h20000000, 32'h20000000,
                                        32'h0, 32'h02000000};
  localparam logic [31:0] V_RD [NV] = '{32'h0200AA54, 32'h0A00AA54, 32'h0800AA54,
                                        32'h0800AA54, 32'h1900AA54, 32'h0100AA54,
                                        32'h2100AA54, 32'h0100AA54, 32'h0300AA54,
                                        32'h0100AA54};
  localparam logic        V_RT [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
  localparam string       V_RQ [NV] = '{"R6", "R7", "R10 R12 R2", "R3", "R8",
                                        "R10 R9", "R11", "R10", "R6", "R10"};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] e, logic we, logic [31:0] wd);
    @(negedge clk);
    ev = e; regWrEn = we; regWrData = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    ev = '0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rstN = 1'b0; idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {regRdData[31:16], 14'h0, retryReq, abortReq},
          {16'h0, 14'h0, 2'b00});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rd", regRdData, 32'h0000AA54);
    check("R1 pulses", {30'h0, retryReq, abortReq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(V_EV[i], V_WE[i], V_WD[i]);
      check(V_RQ[i], regRdData, V_RD[i]);
      check({V_RQ[i], " pulse"}, {30'h0, retryReq, abortReq}, {30'h0, V_RT[i], 1'b0});
      idle();
    end

    // R5: new transaction clears the one loss left over from the table
    apply(8'h08, 0, 0); idle();
    for (int k = 0; k < 15; k++) begin
      apply(8'h02, 0, 0);
      check("R3 retry", {30'h0, retryReq, abortReq}, 32'h2);
      idle();
    end
    check("R3 no flag", {31'h0, regRdData[26]}, 32'h0);
    apply(8'h02, 0, 0);
    check("R4 abort", {30'h0, retryReq, abortReq}, 32'h1);
    check("R4 flag", regRdData, 32'h0500AA54);
    idle();
    @(negedge clk);
    check("R4 single", {31'h0, abortReq}, 32'h0);
    apply(8'h00, 1, 32'h04000000); idle();
    check("R10 clear lost", regRdData, 32'h0100AA54);
    // R4: count restarted, next loss is a retry
    apply(8'h02, 0, 0);
    check("R4 restart", {30'h0, retryReq, abortReq}, 32'h2);
    idle();

    // R5: win interrupts run; loss in same cycle as win is discarded
    apply(8'h04, 0, 0); idle();
    for (int k = 0; k < 15; k++) begin apply(8'h02, 0, 0); idle(); end
    apply(8'h06, 0, 0);
    check("R5 lost+won", {30'h0, retryReq, abortReq}, 32'h0);
    idle();
    for (int k = 0; k < 15; k++) begin apply(8'h02, 0, 0); idle(); end
    check("R5 no abort", {30'h0, retryReq, abortReq, regRdData[26]} , {29'h0, 3'b100});
    apply(8'h02, 0, 0);
    check("R5 abort at 16", {30'h0, retryReq, abortReq}, 32'h1);
    idle();

    // R2 / R1: new straps, reset clears done
    strapSlvAddr = 7'h11; strapMstAddr = 7'h7F;
    do_reset();
    check("R2 new straps", regRdData, 32'h0000FE22);
    apply(8'h80, 0, 0); idle();
    check("R9 loadend", regRdData, 32'h0100FE22);
    apply(8'h00, 1, 32'hFFFFFFFF); idle();
    check("R9 R12 R2 write ones", regRdData, 32'h0100FE22);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule